// File: doc/BRIEF.md
# Keyed Indexed Configuration Port Controller

This block sits behind a pair of adjacent byte-wide host I/O addresses and holds the setup registers of a multi-function peripheral chip. Out of reset it is in run mode and the setup registers cannot be reached. When the host writes an unlock key to the first address, the block enters configuration mode. In that mode the first address loads an index and the second address reads or writes the register the index points at. A lock key written to the first address returns the block to run mode.

A logical-device selector register picks one of several register banks. The per-device indices all refer to the bank it selects. Each device bank holds an enable bit, a primary and a secondary 16-bit base address, two interrupt-line selects and two address-decoder control bytes. One dedicated bank holds a row of pin configuration bytes. Every stored setting drives a block output, so the peripheral logic around the block sees the setup continuously.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the block is in run mode (`cfg_active` = 0), all per-device and pin outputs are 0, and a read at either offset returns 0xFF.
- R2: In run mode, writing 0x55 at offset 0 enters configuration mode and clears the index and the device selector. Any other value written at offset 0 in run mode has no effect.
- R3: In configuration mode, writing 0xAA at offset 0 returns to run mode. Any other value written there, 0x55 included, loads the index register. Settings are kept across the mode change.
- R4: In configuration mode, index 0x07 is the device selector and reads back the last value written to it.
- R5: Index 0x20 reads 0x30 and index 0x21 reads 0x01, whichever device is selected. Writes to them are ignored.
- R6: For the selected device (1, 2, 3, 4, 5 or 7): index 0x30 bit 0 is the enable; 0x60/0x61 hold the primary base, high byte then low byte; 0x62/0x63 hold the secondary base in the same order; 0x70 and 0x72 are the primary and secondary interrupt selects; 0xF0 and 0xF1 are decoder control bytes. All of these read back. The outputs of the written device change on the clock edge that takes the write, and no other device changes.
- R7: With device 8 selected, index 0xC0+n configures pin n (n < 48). Bit 0 is the direction (1 = input), bit 1 is the polarity invert, bit 2 is the combined-IRQ enable and bits 4:3 are the function. Reads return these five bits with bits 7:5 zero.
- R8: An index that the selected device does not implement, and any access while device 0, 6 or a number above 8 is selected, reads 0xFF. Writes to such an index change no output and no readable register.
- R9: In run mode, writes at offset 1 are ignored and reads at either offset return 0xFF.
- R10: Reads have no side effects, and offset 0 always reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Byte write strobe, one cycle per access |
| host_rd | input | 1 | Byte read strobe |
| host_addr | input | 1 | Port offset: 0 = key/index, 1 = data |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational while `host_rd` is high |
| cfg_active | output | 1 | High in configuration mode |
| dev_en | output | 9 | Enable per device number |
| dev_pbase | output | 144 | Primary base, 16 bits per device number |
| dev_sbase | output | 144 | Secondary base, 16 bits per device number |
| dev_irq_a | output | 72 | Primary interrupt select, 8 bits per device number |
| dev_irq_b | output | 72 | Secondary interrupt select, 8 bits per device number |
| pin_dir | output | 48 | Direction per pin, 1 = input |
| pin_inv | output | 48 | Polarity invert per pin |
| pin_irq_en | output | 48 | Combined-IRQ enable per pin |
| pin_func | output | 96 | Function select, 2 bits per pin |

## Verification
Read data is combinational, so it is valid in the same cycle as the read strobe. The bench drives each read on a falling edge and samples it a quarter period later, before the next rising edge. Register writes, the mode change and every exported setting take effect on the first rising edge after the strobe. The bench drives each write on a falling edge and compares outputs at the next falling edge, one edge after the write was taken. Checks that an access was ignored read the relevant registers back or compare the exported outputs in that window, before any further write.

// File: rtl/cfgp_pkg.sv
// Shared constants and types for the keyed configuration port controller.
// Assumes byte-wide host accesses and 8-bit index values.
package cfgp_pkg;
    localparam logic [7:0] KEY_UNLOCK = 8'h55;
    localparam logic [7:0] KEY_LOCK   = 8'hAA;
    localparam logic [7:0] IX_SELECT  = 8'h07;
    localparam logic [7:0] IX_CHIP_ID = 8'h20;
    localparam logic [7:0] IX_CHIP_RV = 8'h21;
    localparam logic [7:0] IX_ENABLE  = 8'h30;
    localparam logic [7:0] IX_PB_HI   = 8'h60;
    localparam logic [7:0] IX_PB_LO   = 8'h61;
    localparam logic [7:0] IX_SB_HI   = 8'h62;
    localparam logic [7:0] IX_SB_LO   = 8'h63;
    localparam logic [7:0] IX_IRQ_A   = 8'h70;
    localparam logic [7:0] IX_IRQ_B   = 8'h72;
    localparam logic [7:0] IX_DEC_A   = 8'hF0;
    localparam logic [7:0] IX_DEC_B   = 8'hF1;
    localparam logic [7:0] CHIP_ID    = 8'h30;
    localparam logic [7:0] CHIP_RV    = 8'h01;
    localparam logic [7:0] RD_IDLE    = 8'hFF;

    typedef enum logic {
        MODE_RUN = 1'b0,
        MODE_CFG = 1'b1
    } port_mode_e;
endpackage

// File: rtl/cfgp_key_fsm.sv
// Mode sequencer with index and device-selector registers.
// Handles the unlock/lock keys at offset 0 and the selector writes.
// Assumes host_wr is a single-cycle strobe.
module cfgp_key_fsm
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       addr,
    input  logic [7:0] wdata,
    output port_mode_e mode,
    output logic [7:0] index,
    output logic [7:0] dev_sel,
    output logic       data_we
);
    logic key_wr;
    logic dat_wr;

    assign key_wr  = wr && !addr;
    assign dat_wr  = wr && addr;
    assign data_we = dat_wr && (mode == MODE_CFG);

    // Mode, index and selector update on key, index and selector writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_RUN;
            index   <= 8'h00;
            dev_sel <= 8'h00;
        end else if (key_wr) begin
            if (mode == MODE_RUN) begin
                if (wdata == KEY_UNLOCK) begin
                    mode    <= MODE_CFG;
                    index   <= 8'h00;
                    dev_sel <= 8'h00;
                end
            end else if (wdata == KEY_LOCK) begin
                mode <= MODE_RUN;
            end else begin
                index <= wdata;
            end
        end else if (data_we && index == IX_SELECT) begin
            dev_sel <= wdata;
        end
    end

    // R2: the unlock key in run mode enters configuration with index and selector cleared
    a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && key_wr && wdata == KEY_UNLOCK)
        |=> (mode == MODE_CFG && index == 8'h00 && dev_sel == 8'h00));

    // R2: other offset-0 values leave run mode untouched
    a_r2_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && !(key_wr && wdata == KEY_UNLOCK))
        |=> (mode == MODE_RUN && $stable(index) && $stable(dev_sel)));

    // R3: the lock key leaves configuration mode
    a_r3_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CFG && key_wr && wdata == KEY_LOCK) |=> (mode == MODE_RUN));

    // R3: any other offset-0 value in configuration mode becomes the index
    a_r3_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CFG && key_wr && wdata != KEY_LOCK)
        |=> (mode == MODE_CFG && index == $past(wdata)));
endmodule

// File: rtl/cfgp_dev_bank.sv
// Register bank of one logical device: enable, two bases, two interrupt
// selects and two decoder bytes. Answers reads only when selected.
// Assumes data_we is already qualified by configuration mode.
module cfgp_dev_bank
    import cfgp_pkg::*;
#(
    parameter int DEV_NUM = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        data_we,
    input  logic [7:0]  index,
    input  logic [7:0]  dev_sel,
    input  logic [7:0]  wdata,
    output logic        rd_hit,
    output logic [7:0]  rd_data,
    output logic        en,
    output logic [15:0] pbase,
    output logic [15:0] sbase,
    output logic [7:0]  irq_a,
    output logic [7:0]  irq_b
);
    localparam logic [7:0] MY_NUM = 8'(DEV_NUM);

    logic       sel;
    logic       bank_we;
    logic [7:0] dec_a;
    logic [7:0] dec_b;
    logic       unused_wbits;

    assign sel          = (dev_sel == MY_NUM);
    assign bank_we      = data_we && sel;
    assign unused_wbits = ^wdata[7:1];

    // Store the byte addressed by the index when this bank is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            pbase <= 16'h0000;
            sbase <= 16'h0000;
            irq_a <= 8'h00;
            irq_b <= 8'h00;
            dec_a <= 8'h00;
            dec_b <= 8'h00;
        end else if (bank_we) begin
            unique case (index)
                IX_ENABLE: en           <= wdata[0];
                IX_PB_HI:  pbase[15:8]  <= wdata;
                IX_PB_LO:  pbase[7:0]   <= wdata;
                IX_SB_HI:  sbase[15:8]  <= wdata;
                IX_SB_LO:  sbase[7:0]   <= wdata;
                IX_IRQ_A:  irq_a        <= wdata;
                IX_IRQ_B:  irq_b        <= wdata;
                IX_DEC_A:  dec_a        <= wdata;
                IX_DEC_B:  dec_b        <= wdata;
                default: ;
            endcase
        end
    end

    // Read-back of the addressed byte; no hit for indices this bank lacks.
    always_comb begin
        rd_hit  = sel;
        rd_data = RD_IDLE;
        unique case (index)
            IX_ENABLE: rd_data = {7'b0, en};
            IX_PB_HI:  rd_data = pbase[15:8];
            IX_PB_LO:  rd_data = pbase[7:0];
            IX_SB_HI:  rd_data = sbase[15:8];
            IX_SB_LO:  rd_data = sbase[7:0];
            IX_IRQ_A:  rd_data = irq_a;
            IX_IRQ_B:  rd_data = irq_b;
            IX_DEC_A:  rd_data = dec_a;
            IX_DEC_B:  rd_data = dec_b;
            default:   rd_hit  = 1'b0;
        endcase
    end

    // R6: a bank not written this cycle keeps all its settings
    a_r6_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable({en, pbase, sbase, irq_a, irq_b, dec_a, dec_b}));

    // R6: an enable write shows on the output one edge later
    a_r6_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && index == IX_ENABLE) |=> (en == $past(wdata[0])));
endmodule

// File: rtl/cfgp_pin_bank.sv
// Pin configuration bank: one 5-bit setting per pin at consecutive indices
// from BASE_IX, reachable only when the bank's device number is selected.
// Assumes BASE_IX + NUM_PINS does not exceed 256.
module cfgp_pin_bank
    import cfgp_pkg::*;
#(
    parameter int          DEV_NUM  = 8,
    parameter int          NUM_PINS = 48,
    parameter logic [7:0]  BASE_IX  = 8'hC0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  data_we,
    input  logic [7:0]            index,
    input  logic [7:0]            dev_sel,
    input  logic [7:0]            wdata,
    output logic                  rd_hit,
    output logic [7:0]            rd_data,
    output logic [NUM_PINS-1:0]   dir,
    output logic [NUM_PINS-1:0]   inv,
    output logic [NUM_PINS-1:0]   irq_en,
    output logic [2*NUM_PINS-1:0] func
);
    localparam logic [7:0] MY_NUM   = 8'(DEV_NUM);
    localparam int         CFG_BITS = 5;

    logic                sel;
    logic [NUM_PINS-1:0] pin_hit;
    logic [CFG_BITS-1:0] pin_cfg [NUM_PINS];
    logic                unused_wbits;

    assign sel          = (dev_sel == MY_NUM);
    assign unused_wbits = ^wdata[7:CFG_BITS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [7:0] PIN_IX = BASE_IX + 8'(p);
        assign pin_hit[p] = sel && (index == PIN_IX);

        // Capture this pin's setting on a data write to its index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pin_cfg[p] <= '0;
            else if (data_we && pin_hit[p])
                pin_cfg[p] <= wdata[CFG_BITS-1:0];
        end

        assign dir[p]          = pin_cfg[p][0];
        assign inv[p]          = pin_cfg[p][1];
        assign irq_en[p]       = pin_cfg[p][2];
        assign func[2*p +: 2]  = pin_cfg[p][4:3];
    end

    // Read-back of the addressed pin's setting.
    always_comb begin
        rd_hit  = |pin_hit;
        rd_data = RD_IDLE;
        for (int p = 0; p < NUM_PINS; p++)
            if (pin_hit[p]) rd_data = {3'b000, pin_cfg[p]};
    end

    // R7: a write to the first pin reaches its decoded fields one edge later
    a_r7_pin_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && sel && index == BASE_IX)
        |=> (dir[0] == $past(wdata[0]) && inv[0] == $past(wdata[1])
             && irq_en[0] == $past(wdata[2]) && func[1:0] == $past(wdata[4:3])));

    // R8: without a write to this bank every pin holds its setting
    a_r8_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_we && |pin_hit) |=> ($stable(dir) && $stable(inv) && $stable(irq_en) && $stable(func)));
endmodule

// File: rtl/cfg_port_ctrl.sv
// Keyed indexed configuration port controller (top).
// Joins the key sequencer, the device banks chosen by DEV_MASK and the
// pin bank, and builds the read multiplexer. Outputs are indexed by device
// number; numbers without a bank drive zero.
module cfg_port_ctrl
    import cfgp_pkg::*;
#(
    parameter int                  NUM_SLOTS = 9,
    parameter logic [NUM_SLOTS-1:0] DEV_MASK = 9'h0BE,
    parameter int                  PIN_DEV   = 8,
    parameter int                  NUM_PINS  = 48,
    parameter logic [7:0]          PIN_BASE  = 8'hC0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic                    host_addr,
    input  logic [7:0]              host_wdata,
    output logic [7:0]              host_rdata,
    output logic                    cfg_active,
    output logic [NUM_SLOTS-1:0]    dev_en,
    output logic [NUM_SLOTS*16-1:0] dev_pbase,
    output logic [NUM_SLOTS*16-1:0] dev_sbase,
    output logic [NUM_SLOTS*8-1:0]  dev_irq_a,
    output logic [NUM_SLOTS*8-1:0]  dev_irq_b,
    output logic [NUM_PINS-1:0]     pin_dir,
    output logic [NUM_PINS-1:0]     pin_inv,
    output logic [NUM_PINS-1:0]     pin_irq_en,
    output logic [2*NUM_PINS-1:0]   pin_func
);
    port_mode_e           mode;
    logic [7:0]           index;
    logic [7:0]           dev_sel;
    logic                 data_we;
    logic [NUM_SLOTS-1:0] slot_hit;
    logic [7:0]           slot_data [NUM_SLOTS];
    logic                 pin_hit;
    logic [7:0]           pin_data;

    assign cfg_active = (mode == MODE_CFG);

    cfgp_key_fsm u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (host_wr),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .mode    (mode),
        .index   (index),
        .dev_sel (dev_sel),
        .data_we (data_we)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (DEV_MASK[s]) begin : g_bank
            cfgp_dev_bank #(.DEV_NUM(s)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .data_we (data_we),
                .index   (index),
                .dev_sel (dev_sel),
                .wdata   (host_wdata),
                .rd_hit  (slot_hit[s]),
                .rd_data (slot_data[s]),
                .en      (dev_en[s]),
                .pbase   (dev_pbase[16*s +: 16]),
                .sbase   (dev_sbase[16*s +: 16]),
                .irq_a   (dev_irq_a[8*s +: 8]),
                .irq_b   (dev_irq_b[8*s +: 8])
            );
        end else begin : g_empty
            assign slot_hit[s]           = 1'b0;
            assign slot_data[s]          = RD_IDLE;
            assign dev_en[s]             = 1'b0;
            assign dev_pbase[16*s +: 16] = 16'h0000;
            assign dev_sbase[16*s +: 16] = 16'h0000;
            assign dev_irq_a[8*s +: 8]   = 8'h00;
            assign dev_irq_b[8*s +: 8]   = 8'h00;
        end
    end

    cfgp_pin_bank #(
        .DEV_NUM  (PIN_DEV),
        .NUM_PINS (NUM_PINS),
        .BASE_IX  (PIN_BASE)
    ) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_we (data_we),
        .index   (index),
        .dev_sel (dev_sel),
        .wdata   (host_wdata),
        .rd_hit  (pin_hit),
        .rd_data (pin_data),
        .dir     (pin_dir),
        .inv     (pin_inv),
        .irq_en  (pin_irq_en),
        .func    (pin_func)
    );

    // Read multiplexer: global indices first, then the selected bank.
    always_comb begin
        host_rdata = RD_IDLE;
        if (host_rd && host_addr && mode == MODE_CFG) begin
            if (index == IX_SELECT)       host_rdata = dev_sel;
            else if (index == IX_CHIP_ID) host_rdata = CHIP_ID;
            else if (index == IX_CHIP_RV) host_rdata = CHIP_RV;
            else if (pin_hit)             host_rdata = pin_data;
            else begin
                for (int s = 0; s < NUM_SLOTS; s++)
                    if (slot_hit[s]) host_rdata = slot_data[s];
            end
        end
    end

    // R9: run mode hides every register from reads
    a_r9_run_reads_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !cfg_active) |-> (host_rdata == RD_IDLE));

    // R10: offset 0 never returns register contents
    a_r10_index_port_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_addr) |-> (host_rdata == RD_IDLE));

    // R5: the identification byte is fixed in configuration mode
    a_r5_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr && cfg_active && index == IX_CHIP_ID) |-> (host_rdata == CHIP_ID));

    // R8: at most one bank claims a read
    a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slot_hit, pin_hit}));
endmodule

// File: tb/cfg_port_ctrl_test.sv
// Directed bench: one task per scenario, each checking its own results.
module cfg_port_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS = 9;
    localparam int PINS  = 48;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                host_wr = 1'b0;
    logic                host_rd = 1'b0;
    logic                host_addr = 1'b0;
    logic [7:0]          host_wdata = 8'h00;
    logic [7:0]          host_rdata;
    logic                cfg_active;
    logic [SLOTS-1:0]    dev_en;
    logic [SLOTS*16-1:0] dev_pbase;
    logic [SLOTS*16-1:0] dev_sbase;
    logic [SLOTS*8-1:0]  dev_irq_a;
    logic [SLOTS*8-1:0]  dev_irq_b;
    logic [PINS-1:0]     pin_dir;
    logic [PINS-1:0]     pin_inv;
    logic [PINS-1:0]     pin_irq_en;
    logic [2*PINS-1:0]   pin_func;

    int checks = 0;
    int errors = 0;

    cfg_port_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cfg_active (cfg_active),
        .dev_en     (dev_en),
        .dev_pbase  (dev_pbase),
        .dev_sbase  (dev_sbase),
        .dev_irq_a  (dev_irq_a),
        .dev_irq_b  (dev_irq_b),
        .pin_dir    (pin_dir),
        .pin_inv    (pin_inv),
        .pin_irq_en (pin_irq_en),
        .pin_func   (pin_func)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Write strobe on a falling edge, taken at the next rising edge,
    // returning at the falling edge after it with the results settled.
    task automatic bus_write(input logic off, input logic [7:0] val);
        @(negedge clk);
        host_addr  = off;
        host_wdata = val;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic off, output logic [7:0] val);
        @(negedge clk);
        host_addr = off;
        host_rd   = 1'b1;
        #(CLK_PERIOD/4);
        val = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] ix, input logic [7:0] val);
        bus_write(1'b0, ix);
        bus_write(1'b1, val);
    endtask

    task automatic reg_read(input logic [7:0] ix, output logic [7:0] val);
        bus_write(1'b0, ix);
        bus_read(1'b1, val);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 mode", cfg_active, 0);
        check("R1 enables", dev_en, 0);
        check("R1 bases", dev_pbase[31:0] | dev_sbase[31:0], 0);
        check("R1 pins", pin_dir | pin_inv | pin_irq_en, 0);
        bus_read(1'b1, v);
        check("R1 read offset1", v, 8'hFF);
        bus_read(1'b0, v);
        check("R1 read offset0", v, 8'hFF);
    endtask

    task automatic t_run_ignored;
        logic [7:0] v;
        bus_write(1'b0, 8'h54);
        check("R2 wrong key", cfg_active, 0);
        bus_write(1'b0, 8'hAA);
        check("R2 lock in run", cfg_active, 0);
        bus_write(1'b1, 8'h01);
        bus_read(1'b1, v);
        check("R9 run read", v, 8'hFF);
        check("R9 run write", dev_en, 0);
    endtask

    task automatic t_enter;
        logic [7:0] v;
        bus_write(1'b0, 8'h55);
        check("R2 unlock", cfg_active, 1);
        bus_read(1'b1, v);
        check("R8 index 0 after entry", v, 8'hFF);
        reg_read(8'h07, v);
        check("R2 selector cleared", v, 8'h00);
        reg_write(8'h07, 8'h05);
        reg_read(8'h07, v);
        check("R4 selector readback", v, 8'h05);
        bus_read(1'b0, v);
        check("R10 offset0 read", v, 8'hFF);
    endtask

    task automatic t_chip_id;
        logic [7:0] v;
        reg_read(8'h20, v);
        check("R5 id", v, 8'h30);
        bus_write(1'b1, 8'h99);
        bus_read(1'b1, v);
        check("R5 id write ignored", v, 8'h30);
        reg_read(8'h21, v);
        check("R5 rev", v, 8'h01);
    endtask

    task automatic t_devices;
        logic [7:0] v;
        reg_write(8'h07, 8'h04);
        reg_write(8'h30, 8'h01);
        check("R6 enable dev4", dev_en, 9'h010);
        reg_write(8'h60, 8'h03);
        reg_write(8'h61, 8'hF8);
        check("R6 pbase dev4", dev_pbase[16*4 +: 16], 16'h03F8);
        reg_write(8'h70, 8'h05);
        check("R6 irq_a dev4", dev_irq_a[8*4 +: 8], 8'h05);
        reg_write(8'h07, 8'h01);
        reg_write(8'h60, 8'h01);
        reg_write(8'h61, 8'hF0);
        reg_write(8'h62, 8'h03);
        reg_write(8'h63, 8'hF6);
        reg_write(8'h72, 8'h0E);
        reg_write(8'hF0, 8'h0C);
        check("R6 pbase dev1", dev_pbase[16*1 +: 16], 16'h01F0);
        check("R6 sbase dev1", dev_sbase[16*1 +: 16], 16'h03F6);
        check("R6 irq_b dev1", dev_irq_b[8*1 +: 8], 8'h0E);
        check("R6 dev4 untouched", dev_pbase[16*4 +: 16], 16'h03F8);
        check("R6 dev1 enable off", dev_en, 9'h010);
        reg_read(8'hF0, v);
        check("R6 decoder readback", v, 8'h0C);
        reg_read(8'h62, v);
        check("R6 sbase hi readback", v, 8'h03);
        reg_write(8'h07, 8'h04);
        reg_read(8'h30, v);
        check("R6 enable readback", v, 8'h01);
    endtask

    task automatic t_pins;
        logic [7:0] v;
        reg_write(8'h07, 8'h08);
        reg_write(8'hC2, 8'hFF);
        check("R7 dir pin2", pin_dir[2], 1);
        check("R7 inv pin2", pin_inv[2], 1);
        check("R7 irq pin2", pin_irq_en[2], 1);
        check("R7 func pin2", pin_func[2*2 +: 2], 2'b11);
        reg_read(8'hC2, v);
        check("R7 readback masks bits 7:5", v, 8'h1F);
        reg_write(8'hC5, 8'h01);
        check("R7 pin5 dir only", {pin_dir[5], pin_inv[5], pin_irq_en[5]}, 3'b100);
        reg_write(8'hE8, 8'h08);
        check("R7 pin40 func", pin_func[2*40 +: 2], 2'b01);
        check("R7 pin40 dir", pin_dir[40], 0);
    endtask

    task automatic t_unimplemented;
        logic [7:0] v;
        reg_write(8'h07, 8'h06);
        reg_write(8'h30, 8'h01);
        reg_read(8'h30, v);
        check("R8 device 6 read", v, 8'hFF);
        check("R8 device 6 write", dev_en, 9'h010);
        reg_write(8'h07, 8'h04);
        reg_write(8'h31, 8'h77);
        reg_read(8'h31, v);
        check("R8 missing index", v, 8'hFF);
        reg_write(8'hC2, 8'h00);
        check("R8 pin index on device bank", pin_dir[2], 1);
        reg_read(8'hC2, v);
        check("R8 pin index read on device bank", v, 8'hFF);
        reg_write(8'h07, 8'h08);
        reg_write(8'h60, 8'h12);
        reg_read(8'h60, v);
        check("R8 base index on pin bank", v, 8'hFF);
        reg_write(8'h07, 8'h09);
        reg_read(8'h30, v);
        check("R8 device 9 read", v, 8'hFF);
    endtask

    task automatic t_key_in_cfg;
        logic [7:0] v;
        bus_write(1'b0, 8'h55);
        check("R3 unlock as index", cfg_active, 1);
        bus_read(1'b1, v);
        check("R3 index 0x55 unimplemented", v, 8'hFF);
        bus_write(1'b0, 8'hAA);
        check("R3 lock", cfg_active, 0);
        check("R3 settings kept", dev_pbase[16*4 +: 16], 16'h03F8);
        bus_write(1'b1, 8'h00);
        check("R9 run data write ignored", dev_en, 9'h010);
        bus_read(1'b1, v);
        check("R9 run read after lock", v, 8'hFF);
        bus_write(1'b0, 8'h55);
        reg_read(8'h07, v);
        check("R2 selector cleared on reentry", v, 8'h00);
        bus_write(1'b0, 8'hAA);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_ignored();
        t_enter();
        t_chip_id();
        t_devices();
        t_pins();
        t_unimplemented();
        t_key_in_cfg();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule